// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block sits beside a small CPU core. It watches for three events that can stop normal execution: a breakpoint request, a decoded background opcode, and two bus faults in a row. When the debug-enable bit is set, any of these events freezes the core. The block then writes a code naming the cause into a 32-bit temporary register and opens a command port so that a debugger can read that code.

When debug is disabled, the same events fall back to normal handling. A breakpoint raises an exception with the breakpoint vector. The background opcode raises an illegal-instruction exception. A double bus fault halts the core permanently.

All outputs are registered. An event presented on a clock edge becomes visible right after that edge. Peripheral and external breakpoint requests share the single breakpoint input.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: After synchronous reset (`rst` high), the outputs are as follows:
  - `freeze`, `halted`, `exc_req`, `cmd_ready` and `rsp_valid` are 0.
  - `atemp` is 0.
  - `core_run` is 1.
- R2: With `dbg_en`=1, an instruction boundary (`insn_valid`=1) with `insn_op`=16'h4AFA sets `freeze` after that edge and loads `atemp` with 32'h0000_0001.
- R3: With `dbg_en`=1, `brk_req`=1 at an instruction boundary sets `freeze` and loads `atemp` with 32'h0000_0000. `brk_req` without `insn_valid` is not acknowledged.
- R4: With `dbg_en`=1, a second `bus_fault` pulse following a first one sets `freeze` and loads `atemp` with {`ssw`, 16'hFFFF}. A `bus_ok` between the two faults clears the pending fault, so the second fault does not enter.
- R5: With `dbg_en`=0, the fallback exceptions are as follows, and `freeze` stays 0:
  - A breakpoint gives a one-cycle `exc_req` with `exc_vec`=8'h0C.
  - The background opcode gives `exc_req` with `exc_vec`=8'h04.
- R6: With `dbg_en`=0, a double bus fault sets `halted`. `halted` stays set until reset, whatever other inputs or commands arrive.
- R7: When several entry events occur in the same cycle, only one is taken. The double fault wins over the breakpoint, and the breakpoint wins over the background opcode.
- R8: A breakpoint request held high is acknowledged once. `brk_req` must go low before it can be acknowledged again.
- R9: `cmd_ready` is 1 only while frozen. Commands given while not frozen are ignored: no response, and `atemp` is unchanged.
- R10: The frozen command set is selected by `cmd_op`:
  - 0 reads `atemp` into `cmd_rdata`.
  - 1 writes `cmd_data` into `atemp` as scratch.
  - 2 resumes.
  - Each accepted command pulses `rsp_valid`.
  - `code_lost` is 1 when the first command after an entry was not a read, and 0 when it was.
- R11: A resume command (`cmd_op`=2) clears `freeze` and sets `core_run` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_en | input | 1 | Debug mode enable |
| brk_req | input | 1 | Breakpoint request (external or peripheral) |
| insn_valid | input | 1 | Instruction boundary / opcode valid |
| insn_op | input | 16 | Decoded opcode |
| bus_fault | input | 1 | Bus fault pulse |
| bus_ok | input | 1 | Successful bus cycle pulse |
| ssw | input | 16 | Special status word captured on double fault |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code (0 read, 1 scratch write, 2 resume) |
| cmd_data | input | 32 | Scratch write data |
| freeze | output | 1 | Debug mode active |
| halted | output | 1 | Core halted by double fault |
| core_run | output | 1 | Core may execute |
| exc_req | output | 1 | Exception request pulse |
| exc_vec | output | 8 | Exception vector number |
| atemp | output | 32 | Temporary register |
| cmd_ready | output | 1 | Command port open |
| rsp_valid | output | 1 | Command response pulse |
| cmd_rdata | output | 32 | Read data |
| code_lost | output | 1 | First command after entry was not a read |

## Verification
The entry logic is driven with each source alone, with the enable bit both set and clear. This separates a frozen entry from an exception or a halt, and a boundary breakpoint from one that is not at a boundary. Sources are also combined in the same cycle, which shows whether the priority picks the right code, vector or halt. A fault, then a good bus cycle, then a fault shows that the pair counter resets. A breakpoint held across a resume shows single acknowledgement. Reading versus writing first after entry separates the two states of the lost-code flag.

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl #(
  parameter int OPW = 16,
  parameter int DW  = 32,
  parameter int VW  = 8,
  parameter logic [OPW-1:0] BGND_OP = 16'h4AFA
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dbg_en,
  input  logic          brk_req,
  input  logic          insn_valid,
  input  logic [OPW-1:0] insn_op,
  input  logic          bus_fault,
  input  logic          bus_ok,
  input  logic [DW/2-1:0] ssw,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_data,
  output logic          freeze,
  output logic          halted,
  output logic          core_run,
  output logic          exc_req,
  output logic [VW-1:0] exc_vec,
  output logic [DW-1:0] atemp,
  output logic          cmd_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] cmd_rdata,
  output logic          code_lost
);
  localparam int HW = DW / 2;
  localparam logic [VW-1:0] VEC_BKPT = VW'(8'h0C);
  localparam logic [VW-1:0] VEC_ILL  = VW'(8'h04);
  localparam logic [1:0] OP_READ = 2'd0, OP_SCR = 2'd1, OP_RES = 2'd2;
  localparam logic [DW-1:0] CODE_BRK = '0;
  localparam logic [DW-1:0] CODE_BG  = DW'(1);

  typedef enum logic [1:0] {S_RUN, S_FRZ, S_HLT} st_t;
  st_t state;
  logic fault_seen, brk_armed, fresh;
  logic at_run, dbl_hit, brk_hit, bg_hit;

  assign at_run    = (state == S_RUN);
  assign dbl_hit   = at_run && bus_fault && fault_seen;
  assign brk_hit   = at_run && insn_valid && brk_req && brk_armed;
  assign bg_hit    = at_run && insn_valid && (insn_op == BGND_OP);
  assign freeze    = (state == S_FRZ);
  assign halted    = (state == S_HLT);
  assign core_run  = at_run;
  assign cmd_ready = freeze;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_RUN;
      fault_seen <= 1'b0;
      brk_armed  <= 1'b1;
      fresh      <= 1'b0;
      code_lost  <= 1'b0;
      exc_req    <= 1'b0;
      exc_vec    <= '0;
      atemp      <= '0;
      rsp_valid  <= 1'b0;
      cmd_rdata  <= '0;
    end else begin
      exc_req   <= 1'b0;
      rsp_valid <= 1'b0;
      if (!brk_req) brk_armed <= 1'b1;
      unique case (state)
        S_RUN: begin
          if (dbl_hit)        fault_seen <= 1'b0;
          else if (bus_fault) fault_seen <= 1'b1;
          else if (bus_ok)    fault_seen <= 1'b0;
          if (dbl_hit) begin
            if (dbg_en) begin
              state     <= S_FRZ;
              atemp     <= {ssw, {HW{1'b1}}};
              fresh     <= 1'b1;
              code_lost <= 1'b0;
            end else begin
              state <= S_HLT;
            end
          end else if (brk_hit) begin
            brk_armed <= 1'b0;
            if (dbg_en) begin
              state     <= S_FRZ;
              atemp     <= CODE_BRK;
              fresh     <= 1'b1;
              code_lost <= 1'b0;
            end else begin
              exc_req <= 1'b1;
              exc_vec <= VEC_BKPT;
            end
          end else if (bg_hit) begin
            if (dbg_en) begin
              state     <= S_FRZ;
              atemp     <= CODE_BG;
              fresh     <= 1'b1;
              code_lost <= 1'b0;
            end else begin
              exc_req <= 1'b1;
              exc_vec <= VEC_ILL;
            end
          end
        end
        S_FRZ: begin
          if (cmd_valid) begin
            if (fresh) begin
              fresh     <= 1'b0;
              code_lost <= (cmd_op != OP_READ);
            end
            rsp_valid <= 1'b1;
            if (cmd_op == OP_READ) cmd_rdata <= atemp;
            if (cmd_op == OP_SCR)  atemp <= cmd_data;
            if (cmd_op == OP_RES)  state <= S_RUN;
          end
        end
        default: ;
      endcase
    end
  end

  a_r2_entry_code: assert property (@(posedge clk) disable iff (rst)
    $rose(freeze) |-> (atemp == CODE_BG || atemp == CODE_BRK || atemp[HW-1:0] == {HW{1'b1}}));
  a_r5_exc_only_running: assert property (@(posedge clk) disable iff (rst)
    exc_req |-> (!freeze && (exc_vec == VEC_BKPT || exc_vec == VEC_ILL)));
  a_r6_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  a_r6_halt_needs_disable: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> !$past(dbg_en));
  a_r9_no_rsp_unfrozen: assert property (@(posedge clk) disable iff (rst)
    (!freeze && cmd_valid) |=> !rsp_valid);
  a_r11_resume: assert property (@(posedge clk) disable iff (rst)
    (freeze && cmd_valid && cmd_op == OP_RES) |=> (!freeze && core_run));
endmodule

// File: tb/dbg_entry_ctrl_bench.sv
`timescale 1ns/1ps
module dbg_entry_ctrl_bench;
  logic clk = 0, rst = 1;
  logic dbg_en = 0, brk_req = 0, insn_valid = 0, bus_fault = 0, bus_ok = 0, cmd_valid = 0;
  logic [15:0] insn_op = 0, ssw = 16'hBEEF;
  logic [1:0] cmd_op = 0;
  logic [31:0] cmd_data = 0;
  logic freeze, halted, core_run, exc_req, cmd_ready, rsp_valid, code_lost;
  logic [7:0] exc_vec;
  logic [31:0] atemp, cmd_rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dbg_entry_ctrl u_dbg_entry_ctrl (.*);

  // {req[3:0], en, brk, iv, op[15:0], prefault, fault, e_frz, e_hlt, e_exc, e_vec[7:0], e_temp[31:0]}
  localparam int NV = 12;
  localparam logic [67:0] VEC [NV] = '{
    {4'd2, 1'b1,1'b0,1'b1,16'h4AFA,1'b0,1'b0, 1'b1,1'b0,1'b0,8'h00,32'h0000_0001}, // R2
    {4'd3, 1'b1,1'b1,1'b1,16'h0000,1'b0,1'b0, 1'b1,1'b0,1'b0,8'h00,32'h0000_0000}, // R3
    {4'd3, 1'b1,1'b1,1'b0,16'h0000,1'b0,1'b0, 1'b0,1'b0,1'b0,8'h00,32'h0000_0000}, // R3 no boundary
    {4'd4, 1'b1,1'b0,1'b0,16'h0000,1'b1,1'b1, 1'b1,1'b0,1'b0,8'h00,32'hBEEF_FFFF}, // R4
    {4'd4, 1'b1,1'b0,1'b0,16'h0000,1'b0,1'b1, 1'b0,1'b0,1'b0,8'h00,32'h0000_0000}, // R4 single
    {4'd5, 1'b0,1'b0,1'b1,16'h4AFA,1'b0,1'b0, 1'b0,1'b0,1'b1,8'h04,32'h0000_0000}, // R5
    {4'd5, 1'b0,1'b1,1'b1,16'h1234,1'b0,1'b0, 1'b0,1'b0,1'b1,8'h0C,32'h0000_0000}, // R5
    {4'd6, 1'b0,1'b0,1'b0,16'h0000,1'b1,1'b1, 1'b0,1'b1,1'b0,8'h00,32'h0000_0000}, // R6
    {4'd7, 1'b1,1'b1,1'b1,16'h4AFA,1'b1,1'b1, 1'b1,1'b0,1'b0,8'h00,32'hBEEF_FFFF}, // R7
    {4'd7, 1'b1,1'b1,1'b1,16'h4AFA,1'b0,1'b0, 1'b1,1'b0,1'b0,8'h00,32'h0000_0000}, // R7
    {4'd7, 1'b0,1'b1,1'b1,16'h4AFA,1'b0,1'b0, 1'b0,1'b0,1'b1,8'h0C,32'h0000_0000}, // R7
    {4'd2, 1'b1,1'b0,1'b1,16'h4AFB,1'b0,1'b0, 1'b0,1'b0,1'b0,8'h00,32'h0000_0000}  // R2 other opcode
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1; dbg_en = 0; brk_req = 0; insn_valid = 0; insn_op = 0;
    bus_fault = 0; bus_ok = 0; cmd_valid = 0; cmd_op = 0; cmd_data = 0;
    step(); step(); rst = 0;
  endtask

  task automatic cmd(input logic [1:0] op, input logic [31:0] d);
    cmd_valid = 1; cmd_op = op; cmd_data = d; step(); cmd_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step();
    for (int i = 0; i < NV; i++) begin
      automatic logic [67:0] v = VEC[i];
      automatic string rq = $sformatf("R%0d vec%0d", v[67:64], i);
      do_reset();
      dbg_en = v[63];
      if (v[44]) begin bus_fault = 1; step(); bus_fault = 0; end
      brk_req = v[62]; insn_valid = v[61]; insn_op = v[60:45]; bus_fault = v[43];
      step();
      brk_req = 0; insn_valid = 0; bus_fault = 0;
      chk({rq, " freeze"}, 32'(freeze), 32'(v[42]));
      chk({rq, " halted"}, 32'(halted), 32'(v[41]));
      chk({rq, " exc_req"}, 32'(exc_req), 32'(v[40]));
      if (v[40]) chk({rq, " exc_vec"}, 32'(exc_vec), 32'(v[39:32]));
      chk({rq, " atemp"}, atemp, v[31:0]);
    end

    // R1 reset state
    do_reset();
    chk("R1 freeze", 32'(freeze), 0); chk("R1 halted", 32'(halted), 0);
    chk("R1 cmd_ready", 32'(cmd_ready), 0); chk("R1 atemp", atemp, 0);
    chk("R1 core_run", 32'(core_run), 1); chk("R1 exc_req", 32'(exc_req), 0);

    // R9 commands ignored while running
    cmd(2'd1, 32'h5555_AAAA);
    chk("R9 rsp_valid", 32'(rsp_valid), 0); chk("R9 atemp", atemp, 0);
    chk("R9 cmd_ready", 32'(cmd_ready), 0);

    // R10 read first, then scratch
    dbg_en = 1; insn_valid = 1; insn_op = 16'h4AFA; step(); insn_valid = 0;
    chk("R9 cmd_ready frozen", 32'(cmd_ready), 1);
    cmd(2'd0, 0);
    chk("R10 rsp_valid", 32'(rsp_valid), 1); chk("R10 rdata", cmd_rdata, 32'h1);
    chk("R10 code_lost", 32'(code_lost), 0);
    cmd(2'd1, 32'hCAFE_0000);
    chk("R10 scratch", atemp, 32'hCAFE_0000); chk("R10 code_lost kept", 32'(code_lost), 0);
    // R11 resume
    cmd(2'd2, 0);
    chk("R11 freeze", 32'(freeze), 0); chk("R11 core_run", 32'(core_run), 1);

    // R10 scratch first loses code
    do_reset(); dbg_en = 1; brk_req = 1; insn_valid = 1; step(); brk_req = 0; insn_valid = 0;
    cmd(2'd1, 32'h1111_2222);
    chk("R10 code_lost set", 32'(code_lost), 1);

    // R8 held breakpoint enters once
    do_reset(); dbg_en = 1; brk_req = 1; insn_valid = 1; step();
    chk("R8 first entry", 32'(freeze), 1);
    cmd_valid = 1; cmd_op = 2'd2; step(); cmd_valid = 0;
    step(); step();
    chk("R8 held no re-entry", 32'(freeze), 0);
    brk_req = 0; step(); brk_req = 1; step();
    chk("R8 re-armed entry", 32'(freeze), 1);
    brk_req = 0; insn_valid = 0;

    // R8 held while disabled: one exception
    do_reset(); brk_req = 1; insn_valid = 1;
    begin
      automatic int n_exc = 0;
      for (int k = 0; k < 4; k++) begin step(); if (exc_req) n_exc++; end
      chk("R8 one exception", 32'(n_exc), 1);
    end
    brk_req = 0; insn_valid = 0;

    // R4 fault, good cycle, fault -> no entry
    do_reset(); dbg_en = 1;
    bus_fault = 1; step(); bus_fault = 0; bus_ok = 1; step(); bus_ok = 0;
    bus_fault = 1; step(); bus_fault = 0;
    chk("R4 cleared pair", 32'(freeze), 0);

    // R6 halt sticky
    do_reset();
    bus_fault = 1; step(); step(); bus_fault = 0;
    chk("R6 halted", 32'(halted), 1);
    dbg_en = 1; insn_valid = 1; insn_op = 16'h4AFA; cmd_valid = 1; cmd_op = 2'd2;
    step(); step(); insn_valid = 0; cmd_valid = 0;
    chk("R6 still halted", 32'(halted), 1); chk("R6 no freeze", 32'(freeze), 0);
    chk("R6 core_run", 32'(core_run), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule